// File: doc/BRIEF.md
# Memory-Mapped GPIO Controller with Pin Interrupts

This block is a GPIO peripheral on an APB slave interface. It holds up to four ports of general-purpose pins. Each port has an output value register, an output-enable (direction) register and a read-only view of its pad inputs. Every pad input goes through a two-flop synchroniser before anything else uses it.

The first port (port 0) also carries per-pin interrupt logic. Each pin can be set up as level or edge sensitive, with a chosen polarity. It has an enable bit and a mask bit, and an optional debounce filter that counts cycles of the main clock. Edge events stay latched until software clears them with a write-one-to-clear register. Level events follow the pin. Unmasked pending pins are combined into one interrupt line.

The bus side has no back-pressure. `pready` is always high, so every transfer completes in its access phase with no wait states. Read data is valid whenever the access phase is present. The pad and interrupt pins are plain level signals.

Top module: `gpio_apb_ctrl`

## Requirements
- R1: After reset every register reads zero, `pad_oe` and `pad_out` are zero and `irq_out` is low.
- R2: For port p, the output value register is at offset 12*p and the output-enable register is at 12*p+4. Both read back what was written, and they drive `pad_out` and `pad_oe` bits [p*PORT_W +: PORT_W], where 1 means the pin is driven.
- R3: The input view of port p at offset 0x50+4*p returns that port's pad inputs after a two-flop synchroniser.
- R4: Reads of unmapped offsets return zero, and writes to unmapped offsets or to the read-only status registers change nothing.
- R5: A port 0 pin whose bit in the type register (0x38) is 0 is level sensitive. A polarity bit (0x3C) of 1 means active high and 0 means active low. Its status follows the pin with no latching.
- R6: A pin whose type bit is 1 latches an edge: a rising edge when its polarity bit is 1, a falling edge when it is 0. The edge stays pending until a 1 is written to its bit of the end-of-interrupt register (0x4C). Bits written as 0 leave their pins pending.
- R7: A pin whose enable bit (0x30) is 0 never shows in the raw status. Clearing the enable bit also discards a latched edge.
- R8: Raw status (0x44) shows enabled, active pins whether masked or not. Status (0x40) equals raw status with the bits set in the mask register (0x34) cleared. `irq_out` is the OR of the status bits.
- R9: When a qualifying edge arrives in the same cycle as an end-of-interrupt write to that pin, the pin stays pending.
- R10: End-of-interrupt writes have no effect on level-sensitive pins.
- R11: A pin whose bit is set in the debounce register (0x48) accepts a new input level only after DEB_CYCLES consecutive clock cycles at that level. A shorter pulse produces no interrupt.
- R12: Pad activity on ports 1 to 3 never changes the status registers or `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 7 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer done, always 1 |
| pad_in | input | NUM_PORTS*PORT_W | Pad input levels |
| pad_out | output | NUM_PORTS*PORT_W | Pad output levels |
| pad_oe | output | NUM_PORTS*PORT_W | Pad output enables |
| irq_out | output | 1 | Combined interrupt |

## Verification
The assertions check the following every cycle:
- A latched edge is held unless its end-of-interrupt bit was written or the pin was disabled.
- A disabled pin carries no pending edge one cycle later.
- Any read of the status register agrees with `irq_out` and never shows a masked pin.
- The outputs are quiet when reset is released.

Only the bench scenarios show the other behaviours:
- Level tracking for both polarities.
- The edge-versus-end-of-interrupt collision.
- A filtered glitch against a held level on a debounced pin.
- The isolation of ports 1 to 3 from the interrupt path.

// File: rtl/gpio_apb_pkg.sv
package gpio_apb_pkg;
  localparam int ADDR_W = 7;
  localparam int PORT_STRIDE = 12;
  localparam int DIR_OFS = 4;
  localparam int EXT_BASE = 'h50;
  localparam int EXT_STRIDE = 4;
  localparam logic [ADDR_W-1:0] OFF_INT_EN   = 7'h30;
  localparam logic [ADDR_W-1:0] OFF_INT_MASK = 7'h34;
  localparam logic [ADDR_W-1:0] OFF_INT_TYPE = 7'h38;
  localparam logic [ADDR_W-1:0] OFF_INT_POL  = 7'h3C;
  localparam logic [ADDR_W-1:0] OFF_STAT     = 7'h40;
  localparam logic [ADDR_W-1:0] OFF_RAW      = 7'h44;
  localparam logic [ADDR_W-1:0] OFF_DEB      = 7'h48;
  localparam logic [ADDR_W-1:0] OFF_EOI      = 7'h4C;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  assign dout = stage2_q;
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int W = 8,
  parameter int CYCLES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic [W-1:0] deb_en,
  output logic [W-1:0] dout
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYCLES - 1);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic             filt_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        filt_q <= 1'b0;
        cnt_q  <= '0;
      end else if (!deb_en[i] || din[i] == filt_q) begin
        filt_q <= din[i];
        cnt_q  <= '0;
      end else if (cnt_q == CNT_LAST) begin
        filt_q <= din[i];
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end

    assign dout[i] = deb_en[i] ? filt_q : din[i];
  end
endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] en,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] typ,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] eoi,
  output logic [W-1:0] pend,
  output logic [W-1:0] raw,
  output logic [W-1:0] stat,
  output logic         irq
);
  logic [W-1:0] prev_q, pend_q, edge_hit, active;

  assign edge_hit = (pol & lvl & ~prev_q) | (~pol & ~lvl & prev_q);
  assign active   = ~(lvl ^ pol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= lvl;
      pend_q <= en & ((pend_q & ~eoi) | (typ & edge_hit));
    end
  end

  assign pend = pend_q;
  assign raw  = en & ((typ & pend_q) | (~typ & active));
  assign stat = raw & ~mask;
  assign irq  = |stat;
endmodule

// File: rtl/gpio_apb_ctrl.sv
module gpio_apb_ctrl
  import gpio_apb_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W = 8,
  parameter int DEB_CYCLES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        psel,
  input  logic                        penable,
  input  logic                        pwrite,
  input  logic [ADDR_W-1:0]           paddr,
  input  logic [31:0]                 pwdata,
  output logic [31:0]                 prdata,
  output logic                        pready,
  input  logic [NUM_PORTS*PORT_W-1:0] pad_in,
  output logic [NUM_PORTS*PORT_W-1:0] pad_out,
  output logic [NUM_PORTS*PORT_W-1:0] pad_oe,
  output logic                        irq_out
);
  localparam int PW = NUM_PORTS * PORT_W;

  logic              wr;
  logic [PORT_W-1:0] wdat;
  logic [PORT_W-1:0] dr_q  [NUM_PORTS];
  logic [PORT_W-1:0] ddr_q [NUM_PORTS];
  logic [PORT_W-1:0] int_en_q, int_mask_q, int_type_q, int_pol_q, deb_q;
  logic [PORT_W-1:0] eoi_bits, lvl_a, edge_pend, raw_st, mask_st;
  logic [PW-1:0]     sync_q;
  logic [31:0]       rdata;

  assign wr     = psel & penable & pwrite;
  assign wdat   = pwdata[PORT_W-1:0];
  assign pready = 1'b1;

  if (PORT_W < 32) begin : g_unused
    logic unused_hi;
    assign unused_hi = ^pwdata[31:PORT_W];
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dr_q[p]  <= '0;
        ddr_q[p] <= '0;
      end else if (wr) begin
        if (paddr == ADDR_W'(p * PORT_STRIDE))           dr_q[p]  <= wdat;
        if (paddr == ADDR_W'(p * PORT_STRIDE + DIR_OFS)) ddr_q[p] <= wdat;
      end
    end
    assign pad_out[p*PORT_W +: PORT_W] = dr_q[p];
    assign pad_oe[p*PORT_W +: PORT_W]  = ddr_q[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en_q   <= '0;
      int_mask_q <= '0;
      int_type_q <= '0;
      int_pol_q  <= '0;
      deb_q      <= '0;
    end else if (wr) begin
      case (paddr)
        OFF_INT_EN:   int_en_q   <= wdat;
        OFF_INT_MASK: int_mask_q <= wdat;
        OFF_INT_TYPE: int_type_q <= wdat;
        OFF_INT_POL:  int_pol_q  <= wdat;
        OFF_DEB:      deb_q      <= wdat;
        default: ;
      endcase
    end
  end

  assign eoi_bits = (wr && paddr == OFF_EOI) ? wdat : '0;

  gpio_sync #(.W(PW)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(sync_q)
  );

  gpio_debounce #(.W(PORT_W), .CYCLES(DEB_CYCLES)) u_deb (
    .clk(clk), .rst_n(rst_n), .din(sync_q[PORT_W-1:0]), .deb_en(deb_q), .dout(lvl_a)
  );

  gpio_irq_core #(.W(PORT_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_a), .en(int_en_q), .mask(int_mask_q),
    .typ(int_type_q), .pol(int_pol_q), .eoi(eoi_bits), .pend(edge_pend),
    .raw(raw_st), .stat(mask_st), .irq(irq_out)
  );

  always_comb begin
    rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (paddr == ADDR_W'(p * PORT_STRIDE))           rdata = 32'(dr_q[p]);
      if (paddr == ADDR_W'(p * PORT_STRIDE + DIR_OFS)) rdata = 32'(ddr_q[p]);
      if (paddr == ADDR_W'(EXT_BASE + p * EXT_STRIDE)) rdata = 32'(sync_q[p*PORT_W +: PORT_W]);
    end
    case (paddr)
      OFF_INT_EN:   rdata = 32'(int_en_q);
      OFF_INT_MASK: rdata = 32'(int_mask_q);
      OFF_INT_TYPE: rdata = 32'(int_type_q);
      OFF_INT_POL:  rdata = 32'(int_pol_q);
      OFF_STAT:     rdata = 32'(mask_st);
      OFF_RAW:      rdata = 32'(raw_st);
      OFF_DEB:      rdata = 32'(deb_q);
      default: ;
    endcase
  end

  assign prdata = rdata;
endmodule

// File: rtl/gpio_apb_ctrl_chk.sv
module gpio_apb_ctrl_chk #(
  parameter int W = 8,
  parameter int PW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [6:0]    paddr,
  input logic [31:0]   prdata,
  input logic [PW-1:0] pad_oe,
  input logic          irq_out,
  input logic [W-1:0]  int_en,
  input logic [W-1:0]  int_mask,
  input logic [W-1:0]  pend,
  input logic [W-1:0]  eoi
);
  logic stat_rd;
  assign stat_rd = psel && penable && !pwrite && paddr == 7'h40;

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!irq_out && pad_oe == '0)); // R1

  AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend & ~eoi & int_en) & ~pend) == '0)); // R6

  AST_DISABLED_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(~int_en) & pend) == '0)); // R7

  AST_STATUS_MATCHES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> ((prdata != '0) == irq_out)); // R8

  AST_MASKED_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> ((prdata[W-1:0] & int_mask) == '0)); // R8
endmodule

bind gpio_apb_ctrl gpio_apb_ctrl_chk #(.W(PORT_W), .PW(NUM_PORTS*PORT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .pad_oe(pad_oe), .irq_out(irq_out),
  .int_en(int_en_q), .int_mask(int_mask_q), .pend(edge_pend), .eoi(eoi_bits)
);

// File: tb/sim_gpio_apb_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_apb_ctrl;
  localparam int NP = 4, PWD = 8, PW = NP * PWD, DEB = 4;

  logic clk = 0, rst_n = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [6:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata;
  logic pready, irq_out;
  logic [PW-1:0] pad_in = '0, pad_out, pad_oe;
  logic probe_req = 0;
  logic done = 0;
  int checks = 0, fails = 0;

  int          q_sel[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  gpio_apb_ctrl #(.NUM_PORTS(NP), .PORT_W(PWD), .DEB_CYCLES(DEB)) u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq_out(irq_out)
  );

  // monitor: pops the scoreboard when a read completes or a probe is raised
  always @(negedge clk) begin
    if ((psel && penable && !pwrite) || probe_req) begin
      if (q_sel.size() == 0) begin
        fails++;
        $display("FAIL scoreboard empty: got none expected item");
      end else begin
        int sel;
        logic [31:0] exp, act;
        string tag;
        sel = q_sel.pop_front(); exp = q_exp.pop_front(); tag = q_tag.pop_front();
        case (sel)
          0: act = prdata;
          1: act = {31'b0, irq_out};
          2: act = 32'(pad_out);
          default: act = 32'(pad_oe);
        endcase
        checks++;
        if (act !== exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic apb_wr(input logic [6:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(posedge clk); #1 penable = 1;
    @(posedge clk); #1 psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic exp_rd(input logic [6:0] a, input logic [31:0] e, input string tag);
    q_sel.push_back(0); q_exp.push_back(e); q_tag.push_back(tag);
    @(posedge clk); #1;
    psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(posedge clk); #1 penable = 1;
    @(posedge clk); #1 psel = 0; penable = 0;
  endtask

  task automatic exp_sig(input int sel, input logic [31:0] e, input string tag);
    q_sel.push_back(sel); q_exp.push_back(e); q_tag.push_back(tag);
    @(posedge clk); #1 probe_req = 1;
    @(posedge clk); #1 probe_req = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(1);
    // R1 reset state
    exp_sig(1, 0, "R1 irq after reset");
    exp_sig(3, 0, "R1 pad_oe after reset");
    exp_sig(2, 0, "R1 pad_out after reset");
    exp_rd(7'h00, 0, "R1 data reg");
    exp_rd(7'h30, 0, "R1 enable reg");
    exp_rd(7'h48, 0, "R1 debounce reg");

    // R2 data / direction
    apb_wr(7'h00, 32'hA5); apb_wr(7'h04, 32'h0F);
    apb_wr(7'h18, 32'h3C); apb_wr(7'h28, 32'h81);
    exp_rd(7'h00, 32'hA5, "R2 port0 data");
    exp_rd(7'h04, 32'h0F, "R2 port0 dir");
    exp_rd(7'h18, 32'h3C, "R2 port2 data");
    exp_sig(2, 32'h003C00A5, "R2 pad_out");
    exp_sig(3, 32'h8100000F, "R2 pad_oe");

    // R3 input view
    pad_in = 32'h12345678;
    wait_cyc(4);
    exp_rd(7'h50, 32'h78, "R3 port0 input");
    exp_rd(7'h54, 32'h56, "R3 port1 input");
    exp_rd(7'h5C, 32'h12, "R3 port3 input");
    pad_in = '0;
    wait_cyc(4);

    // R4 unmapped / read-only
    exp_rd(7'h60, 0, "R4 unmapped read");
    apb_wr(7'h08, 32'hFF);
    exp_rd(7'h08, 0, "R4 unmapped write");
    apb_wr(7'h44, 32'hFF);
    exp_rd(7'h44, 0, "R4 raw status write ignored");

    // R5 level, pin 0
    apb_wr(7'h38, 0); apb_wr(7'h3C, 32'h01); apb_wr(7'h30, 32'h01);
    exp_sig(1, 0, "R5 level inactive");
    pad_in[0] = 1; wait_cyc(4);
    exp_sig(1, 1, "R5 active high asserted");
    exp_rd(7'h40, 32'h01, "R5 status bit0");
    apb_wr(7'h4C, 32'h01);
    exp_sig(1, 1, "R10 eoi ignored by level");
    pad_in[0] = 0; wait_cyc(4);
    exp_sig(1, 0, "R5 follows pin low");
    apb_wr(7'h3C, 32'h00);
    exp_sig(1, 1, "R5 active low asserted");
    apb_wr(7'h30, 0);
    exp_sig(1, 0, "R7 disabled level");
    exp_rd(7'h44, 0, "R7 raw zero when disabled");

    // R6 edge, pin 1 rising
    apb_wr(7'h38, 32'h02); apb_wr(7'h3C, 32'h02); apb_wr(7'h30, 32'h02);
    pad_in[1] = 1; wait_cyc(4);
    exp_sig(1, 1, "R6 rising latched");
    pad_in[1] = 0; wait_cyc(4);
    exp_sig(1, 1, "R6 held after pin drop");
    exp_rd(7'h40, 32'h02, "R6 status bit1");
    apb_wr(7'h4C, 32'h01);
    exp_sig(1, 1, "R6 eoi other bit");
    apb_wr(7'h4C, 32'h02);
    exp_sig(1, 0, "R6 eoi clears");
    // falling
    apb_wr(7'h3C, 32'h00);
    pad_in[1] = 1; wait_cyc(4);
    exp_sig(1, 0, "R6 rise ignored when falling");
    pad_in[1] = 0; wait_cyc(4);
    exp_sig(1, 1, "R6 falling latched");
    apb_wr(7'h4C, 32'h02);
    apb_wr(7'h3C, 32'h02);

    // R8 mask
    apb_wr(7'h34, 32'h02);
    pad_in[1] = 1; wait_cyc(4);
    exp_sig(1, 0, "R8 masked irq");
    exp_rd(7'h40, 0, "R8 masked status");
    exp_rd(7'h44, 32'h02, "R8 raw shows masked");
    apb_wr(7'h34, 0);
    exp_sig(1, 1, "R8 unmasked irq");

    // R7 disable drops pending edge
    apb_wr(7'h30, 0);
    exp_rd(7'h44, 0, "R7 raw after disable");
    apb_wr(7'h30, 32'h02);
    exp_rd(7'h44, 0, "R7 pending discarded");
    exp_sig(1, 0, "R7 irq after re-enable");
    pad_in[1] = 0; wait_cyc(4);

    // R9 edge coincident with eoi
    pad_in[1] = 1; wait_cyc(4);
    pad_in[1] = 0; wait_cyc(4);
    exp_sig(1, 1, "R9 pending before collision");
    @(posedge clk); #1 pad_in[1] = 1;
    @(posedge clk); #1 psel = 1; pwrite = 1; paddr = 7'h4C; pwdata = 32'h02;
    @(posedge clk); #1 penable = 1;
    @(posedge clk); #1 psel = 0; penable = 0; pwrite = 0;
    wait_cyc(2);
    exp_sig(1, 1, "R9 edge wins over eoi");
    apb_wr(7'h4C, 32'h02);
    exp_sig(1, 0, "R9 later eoi clears");
    pad_in[1] = 0;
    apb_wr(7'h30, 0); apb_wr(7'h38, 0);
    wait_cyc(4);

    // R11 debounce, pin 2 level high
    apb_wr(7'h3C, 32'h04); apb_wr(7'h48, 32'h04); apb_wr(7'h30, 32'h04);
    pad_in[2] = 1; wait_cyc(2);
    pad_in[2] = 0; wait_cyc(10);
    exp_sig(1, 0, "R11 glitch filtered");
    pad_in[2] = 1; wait_cyc(2);
    exp_sig(1, 0, "R11 not yet accepted");
    wait_cyc(6);
    exp_sig(1, 1, "R11 held level accepted");
    pad_in[2] = 0;
    apb_wr(7'h30, 0); apb_wr(7'h48, 0);
    wait_cyc(8);

    // R12 other ports isolated
    apb_wr(7'h3C, 32'hFF); apb_wr(7'h30, 32'hFF);
    pad_in[31:8] = 24'hFFFFFF; wait_cyc(4);
    exp_sig(1, 0, "R12 irq unaffected");
    exp_rd(7'h44, 0, "R12 raw unaffected");
    exp_rd(7'h54, 32'hFF, "R12 port1 input visible");

    wait_cyc(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule